// File: doc/BRIEF.md
# Periodic Battery Load-Test Sequencer

This block decides when a backup battery is put under a test load and keeps the warning that reports a weak battery. Once the main supply is reported valid, the block waits for a recovery delay. It then runs a first load test, the power-up test. After that it runs a test at a fixed period for as long as the supply stays valid. During each test the block drives a load-enable output for a fixed window. It samples an external "battery below trip" comparator once, on the last cycle of that window. The analog load and the comparator are outside the block.

The warning is sticky. A failing test sets it, and a passing periodic test leaves it set. Only a passing power-up test, after a fresh supply rise, can clear it. A supply failure stops all activity at once. A test cut short by a supply failure leaves the warning as it was. The warning output is an open-drain pull-down enable. The recovery delay, the window and the period are counted in clock cycles and set by parameters, so the same logic serves a real day-long schedule and a short simulation.

Top module: `batt_test_seq`

## Requirements
- R1: While `rst_n` is low, `load_en` is 0 and `warn_pd` is 0.
- R2: When `supply_ok` is first sampled high at a clock edge after being low, `load_en` rises exactly `RECOV_CYC` edges later. This power-up test runs whether or not the warning is active.
- R3: Every test that is not aborted holds `load_en` high for exactly `WINDOW_CYC` cycles.
- R4: While the supply stays valid, each later test starts exactly `PERIOD_CYC` cycles after the start of the test before it.
- R5: `batt_low` (1 = battery below trip) is sampled only on the last cycle of a test window. If it is 1 there, `warn_pd` becomes 1 at the same edge where `load_en` falls. A value of `batt_low` on any other cycle has no effect. `warn_pd` = 1 means the open-drain warning line is pulled low, which is the active state.
- R6: A passing periodic test (not the first after power-up) never clears `warn_pd`.
- R7: A power-up test that passes clears `warn_pd` at the edge where its window ends.
- R8: When `supply_ok` is sampled low, `load_en` is 0 from the next cycle on and no timing continues. An aborted test leaves `warn_pd` unchanged, even if `batt_low` is 1 on the abort cycle. The next supply rise restarts the sequence at R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all timing is counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Main supply within tolerance (1 = valid) |
| batt_low | input | 1 | Comparator result, 1 = battery below trip point |
| load_en | output | 1 | Connects the test load to the battery (1 = connected) |
| warn_pd | output | 1 | Open-drain pull-down enable for the warning line (1 = warning active) |

## Verification
The test window starts `RECOV_CYC` edges after the supply-valid edge and repeats every `PERIOD_CYC` edges. Its warning result appears at the same edge where `load_en` drops. A supply loss clears `load_en` one edge after it is sampled. The bench keeps a cycle counter for the time since the supply rose, from which it derives the expected `load_en` and the expected warning. It checks both one nanosecond after every edge. Scenario checks wait for a named phase of the window before they drive the supply or the comparator. They sample on the edge count that the rules above give.

// File: rtl/bts_pkg.sv
package bts_pkg;

  typedef enum logic [1:0] {
    PH_OFF   = 2'd0,
    PH_RECOV = 2'd1,
    PH_TEST  = 2'd2,
    PH_WAIT  = 2'd3
  } phase_e;

  // Bits needed to count 0 .. max(a,b)-1
  function automatic int unsigned cnt_width(int unsigned a, int unsigned b);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m < 3) ? 2 : $clog2(m);
  endfunction

  // Length of a phase in cycles
  function automatic int unsigned phase_len(phase_e ph, int unsigned rec,
                                            int unsigned win, int unsigned per);
    case (ph)
      PH_RECOV: return rec;
      PH_TEST:  return win;
      PH_WAIT:  return per - win;
      default:  return 1;
    endcase
  endfunction

  // Warning update at the end of a completed window
  function automatic logic flag_next(logic cur, logic powerup, logic low);
    if (low)     return 1'b1;
    if (powerup) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/bts_phase_timer.sv
module bts_phase_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic [CNT_W-1:0] len,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (run)     cnt_q <= cnt_q + 1'b1;
  end

  assign last = run && (cnt_q == len - 1'b1);
endmodule

// File: rtl/bts_ctrl.sv
module bts_ctrl
  import bts_pkg::*;
#(
  parameter int unsigned RECOV_CYC  = 16,
  parameter int unsigned WINDOW_CYC = 4,
  parameter int unsigned PERIOD_CYC = 64
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   supply_ok,
  output phase_e phase_o,
  output logic   win_last_o,
  output logic   pu_pending_o
);
  localparam int unsigned CNT_W = cnt_width(RECOV_CYC, PERIOD_CYC);

  phase_e           ph_q, ph_d;
  logic             tmr_last, tmr_restart, tmr_run;
  logic [CNT_W-1:0] len;
  logic             pu_q;

  assign len = CNT_W'(phase_len(ph_q, RECOV_CYC, WINDOW_CYC, PERIOD_CYC));

  always_comb begin
    ph_d = ph_q;
    if (ph_q == PH_OFF) begin
      if (supply_ok) ph_d = PH_RECOV;
    end else if (!supply_ok) begin
      ph_d = PH_OFF;
    end else if (tmr_last) begin
      case (ph_q)
        PH_RECOV: ph_d = PH_TEST;
        PH_TEST:  ph_d = PH_WAIT;
        PH_WAIT:  ph_d = PH_TEST;
        default:  ph_d = PH_OFF;
      endcase
    end
  end

  assign tmr_run     = (ph_q != PH_OFF);
  assign tmr_restart = (ph_d != ph_q) || (ph_q == PH_OFF);

  bts_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (tmr_restart),
    .run     (tmr_run),
    .len     (len),
    .last    (tmr_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_OFF;
    else        ph_q <= ph_d;
  end

  assign win_last_o = (ph_q == PH_TEST) && tmr_last && supply_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           pu_q <= 1'b0;
    else if (ph_q == PH_OFF && supply_ok) pu_q <= 1'b1;
    else if (win_last_o)                  pu_q <= 1'b0;
  end

  assign phase_o      = ph_q;
  assign pu_pending_o = pu_q;
endmodule

// File: rtl/bts_warn_flag.sv
module bts_warn_flag
  import bts_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic eval,
  input  logic powerup,
  input  logic low,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (eval) flag <= flag_next(flag, powerup, low);
  end
endmodule

// File: rtl/batt_test_seq.sv
module batt_test_seq
  import bts_pkg::*;
#(
  parameter int unsigned RECOV_CYC  = 6554,
  parameter int unsigned WINDOW_CYC = 32768,
  parameter int unsigned PERIOD_CYC = 32'd2831155200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic batt_low,
  output logic load_en,
  output logic warn_pd
);
  phase_e phase;
  logic   win_last;
  logic   pu_pending;

  bts_ctrl #(
    .RECOV_CYC  (RECOV_CYC),
    .WINDOW_CYC (WINDOW_CYC),
    .PERIOD_CYC (PERIOD_CYC)
  ) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .phase_o      (phase),
    .win_last_o   (win_last),
    .pu_pending_o (pu_pending)
  );

  bts_warn_flag flag_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .eval    (win_last),
    .powerup (pu_pending),
    .low     (batt_low),
    .flag    (warn_pd)
  );

  assign load_en = (phase == PH_TEST);
endmodule

// File: rtl/bts_sva.sv
module bts_sva #(
  parameter int unsigned WINDOW_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic batt_low,
  input logic load_en,
  input logic warn_pd,
  input logic win_last,
  input logic pu_pending
);
  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_q <= 0;
    else if (load_en) run_q <= run_q + 1;
    else              run_q <= 0;
  end

  p_supply_cut_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !load_en);

  p_hold_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !win_last |=> $stable(warn_pd));

  p_fail_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_last && batt_low) |=> warn_pd);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_last && !pu_pending) |=> !$fell(warn_pd));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_last && pu_pending && !batt_low) |=> !warn_pd);

  p_window_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> (run_q < WINDOW_CYC));

  p_window_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(load_en) && $past(supply_ok)) |-> (run_q == WINDOW_CYC));
endmodule

bind batt_test_seq bts_sva #(.WINDOW_CYC(WINDOW_CYC)) sva_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .supply_ok  (supply_ok),
  .batt_low   (batt_low),
  .load_en    (load_en),
  .warn_pd    (warn_pd),
  .win_last   (win_last),
  .pu_pending (pu_pending)
);

// File: tb/batt_test_seq_tb.sv
module batt_test_seq_tb_top;
  localparam int RC = 5;
  localparam int WC = 3;
  localparam int PC = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0;
  logic batt_low = 1'b0;
  wire  load_en, warn_pd;

  always #2 clk = ~clk;

  int   n_chk = 0;
  int   n_err = 0;
  int   m_t = -1;
  logic m_pu = 1'b0;
  logic m_warn = 1'b0;
  int   mode = 0;
  logic done = 1'b0;

  batt_test_seq #(.RECOV_CYC(RC), .WINDOW_CYC(WC), .PERIOD_CYC(PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .batt_low(batt_low),
    .load_en(load_en), .warn_pd(warn_pd)
  );

  task automatic chk(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic in_win(int t);
    return (t >= RC) && (((t - RC) % PC) < WC);
  endfunction

  function automatic logic win_end(int t);
    return (t >= RC) && (((t - RC) % PC) == WC - 1);
  endfunction

  function automatic string load_tag(int t);
    if (t < 0)       return "R8";
    if (t < RC)      return "R2";
    if (t - RC < PC) return "R3";
    return "R4";
  endfunction

  // Arithmetic model: time since supply rise; checked 1 ns after every edge
  initial begin
    logic ok, low, rs;
    forever begin
      @(posedge clk);
      ok = supply_ok; low = batt_low; rs = rst_n;
      if (!rs) begin
        m_t = -1; m_pu = 1'b0; m_warn = 1'b0;
      end else if (!ok) begin
        m_t = -1;
      end else if (m_t < 0) begin
        m_t = 0; m_pu = 1'b1;
      end else begin
        if (win_end(m_t)) begin
          if (low) m_warn = 1'b1;
          else if (m_pu) m_warn = 1'b0;
          m_pu = 1'b0;
        end
        m_t++;
      end
      #1;
      if (rs) begin
        chk(load_tag(m_t), int'(load_en), int'(in_win(m_t)), "load_en per cycle");
        chk("R5", int'(warn_pd), int'(m_warn), "warn_pd per cycle");
      end
    end
  end

  // Comparator driver: 0 pass, 1 fail, 2 fail except window end, 3 fail only at periodic window end
  initial begin
    forever begin
      @(posedge clk);
      #3;
      case (mode)
        1:       batt_low = 1'b1;
        2:       batt_low = !win_end(m_t);
        3:       batt_low = win_end(m_t) && (m_t >= RC + PC);
        default: batt_low = 1'b0;
      endcase
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_phase(int ph);
    do step(1); while (m_t < RC || ((m_t - RC) % PC) != ph);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    step(3);
    chk("R1", int'(load_en), 0, "load_en in reset");
    chk("R1", int'(warn_pd), 0, "warn_pd in reset");
    rst_n = 1'b1;
    step(2);

    // low comparator away from window end is ignored
    mode = 2; supply_ok = 1'b1;
    step(RC + 2 * PC + 2);
    chk("R5", int'(warn_pd), 0, "batt_low off last cycle ignored");

    // periodic failure sets warning
    mode = 3;
    step(PC + 1);
    chk("R5", int'(warn_pd), 1, "failing periodic test sets warning");

    // passing periodic tests keep it
    mode = 0;
    step(2 * PC);
    chk("R6", int'(warn_pd), 1, "passing periodic test keeps warning");

    // abort in the middle of a window
    wait_phase(1);
    supply_ok = 1'b0;
    step(1);
    chk("R8", int'(load_en), 0, "load off after supply loss");
    step(4);
    chk("R8", int'(warn_pd), 1, "abort keeps warning");

    // power-up test with warning active, failing
    mode = 1; supply_ok = 1'b1;
    step(RC);
    chk("R2", int'(load_en), 0, "load still off at end of recovery");
    step(1);
    chk("R2", int'(load_en), 1, "power-up test starts with warning active");
    step(WC);
    chk("R5", int'(warn_pd), 1, "failing power-up test keeps warning");

    // power cycle, passing power-up test clears
    supply_ok = 1'b0;
    step(3);
    mode = 0; supply_ok = 1'b1;
    step(RC + WC);
    chk("R7", int'(warn_pd), 1, "warning held until window end");
    step(1);
    chk("R7", int'(warn_pd), 0, "passing power-up test clears warning");

    // abort on the last window cycle with comparator low
    wait_phase(WC - 1);
    mode = 1; supply_ok = 1'b0;
    step(1);
    chk("R8", int'(load_en), 0, "load off after abort on last cycle");
    step(2);
    chk("R8", int'(warn_pd), 0, "abort on last cycle ignores batt_low");

    mode = 0; supply_ok = 1'b1;
    step(RC + 3 * PC);
    chk("R4", int'(warn_pd), 0, "periodic passes leave clear warning");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule